// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block gives a host a register-level path to a three-wire serial configuration EEPROM of 64 sixteen-bit words. Instead of toggling the serial pins itself, the host writes one 16-bit command word. The upper byte must be zero. Bits 7:6 select the operation and bits 5:0 give the word address. The block then generates the whole serial frame on its own serial clock, chip-select and data-out pins, and captures the data-in pin for reads.

A 16-bit data register works in both directions. A finished read leaves the word there, and a write command takes its payload from it. The command register readback reports three things: an in-progress flag, the state of the write-enable latch, and a sticky flag that records commands lost because they arrived while a frame was running.

The frame begins with a start bit of 1. Next come the 2-bit opcode and the 6-bit address. Reads and writes then add 16 data bits. All fields are sent MSB first. The serial clock runs at the system clock divided by `2*CLK_DIV`. Data out changes while the serial clock is low, and the device is expected to sample it on the rising edge.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: A command word of 0x0080 | addr reads word addr. When the in-progress flag drops, the data register holds that word.
- R2: A command word of 0x0040 | addr sends the current data register as 16 data bits after the header, which stores it into word addr. This applies only while the write-enable latch is set.
- R3: A command word of 0x00C0 | addr sends a 9-bit header only, which sets word addr to 0xFFFF. This applies only while the write-enable latch is set.
- R4: The command word 0x0030 sends a 9-bit header with opcode 00 and address bits 5:4 equal to 11. It sets the write-enable latch, which reads back on command register bit 14 until reset.
- R5: Some commands are ignored: they start no frame, keep bit 15 at 0 and leave the EEPROM unchanged. These are write and erase commands while the write-enable latch is clear, and commands with a nonzero upper byte.
- R6: Command register bit 15 reads 1 from the cycle after a command is accepted. It stays 1 for exactly `2*CLK_DIV` cycles per frame bit: 25 bits for read and write, 9 for erase and write-enable.
- R7: A command written while bit 15 is 1 is dropped and sets command register bit 13. Bit 13 stays set until reset, and the running frame completes unchanged.
- R8: Each frame raises chip-select for its whole length, sends the start bit, opcode and address, then any data, all MSB first, with one serial clock rising edge per bit. Serial clock and chip-select are low whenever bit 15 is 0.
- R9: The data register keeps a read result until the host writes it or another read finishes. If a host data write and a read completion fall in the same cycle, the read result wins.
- R10: After reset the command register reads 0x0000, the data register reads 0x0000 and the write-enable latch is clear. Serial clock and chip-select are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 16 | Command word |
| data_wr_i | input | 1 | Data register write strobe |
| data_wdata_i | input | 16 | Data register write value |
| cmd_rdata_o | output | 16 | Command register readback: bit 15 busy, bit 14 write enabled, bit 13 dropped-command error |
| data_rdata_o | output | 16 | Data register readback |
| ee_sk_o | output | 1 | Serial clock to the EEPROM |
| ee_cs_o | output | 1 | Chip-select to the EEPROM |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |

## Verification
Two things can hit the data register in the same clock: a host data-register write and the completion of a read frame. The bench counts cycles from the accepting edge to the last falling serial clock. It places a host write of 0xBEEF exactly on the completion edge, then expects the read word rather than 0xBEEF. The second overlap is a command written during a running read. The bench judges it by bit 13 becoming set and by the first read's word arriving intact, with no second frame on the serial pins.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 16;
    localparam int HDR_W   = 3 + ADDR_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int BCNT_W  = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        K_NONE,
        K_READ,
        K_WRITE,
        K_ERASE,
        K_UNLOCK
    } cmd_kind_e;
endpackage

// File: rtl/eeprom_cmd_decode.sv
module eeprom_cmd_decode
    import eeprom_cmd_pkg::*;
(
    input  logic        cmd_wr,
    input  logic [15:0] cmd_word,
    input  logic        wen,
    input  logic        busy,
    output cmd_kind_e   kind,
    output logic        start,
    output logic        err_set,
    output logic        set_wen
);
    logic permit;

    always_comb begin
        kind = K_NONE;
        if (cmd_word[15:8] == 8'h00) begin
            case (cmd_word[7:6])
                2'b10:   kind = K_READ;
                2'b01:   kind = K_WRITE;
                2'b11:   kind = K_ERASE;
                default: kind = (cmd_word[5:4] == 2'b11) ? K_UNLOCK : K_NONE;
            endcase
        end
        permit  = (kind == K_READ) || (kind == K_UNLOCK) ||
                  (((kind == K_WRITE) || (kind == K_ERASE)) && wen);
        start   = cmd_wr && !busy && permit;
        err_set = cmd_wr && busy;
        set_wen = start && (kind == K_UNLOCK);
    end
endmodule

// File: rtl/eeprom_serial_shifter.sv
module eeprom_serial_shifter
    import eeprom_cmd_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic [BCNT_W-1:0]  last_idx,
    input  logic               capture,
    input  logic               sdo,
    output logic               busy,
    output logic               sk,
    output logic               cs,
    output logic               sdi,
    output logic               rd_done,
    output logic [DATA_W-1:0]  rd_word
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic               busy;
        logic               sk;
        logic [DW-1:0]      div;
        logic [BCNT_W-1:0]  bit_cnt;
        logic [BCNT_W-1:0]  last;
        logic               capture;
        logic [FRAME_W-1:0] tx;
        logic [DATA_W-1:0]  rx;
    } shf_t;

    shf_t q, d;
    logic done;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy    = 1'b1;
                d.sk      = 1'b0;
                d.div     = DW'(CLK_DIV - 1);
                d.bit_cnt = '0;
                d.last    = last_idx;
                d.capture = capture;
                d.tx      = frame;
                d.rx      = '0;
            end
        end else if (q.div != '0) begin
            d.div = q.div - 1'b1;
        end else begin
            d.div = DW'(CLK_DIV - 1);
            d.sk  = !q.sk;
            if (!q.sk) begin
                if (q.capture && (q.bit_cnt >= BCNT_W'(HDR_W)))
                    d.rx = {q.rx[DATA_W-2:0], sdo};
            end else if (q.bit_cnt == q.last) begin
                d.busy = 1'b0;
                d.sk   = 1'b0;
                done   = 1'b1;
            end else begin
                d.bit_cnt = q.bit_cnt + 1'b1;
                d.tx      = {q.tx[FRAME_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign sk      = q.sk;
    assign cs      = q.busy;
    assign sdi     = q.busy & q.tx[FRAME_W-1];
    assign rd_done = done & q.capture;
    assign rd_word = q.rx;
endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
    import eeprom_cmd_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr_i,
    input  logic [15:0] cmd_wdata_i,
    input  logic        data_wr_i,
    input  logic [15:0] data_wdata_i,
    output logic [15:0] cmd_rdata_o,
    output logic [15:0] data_rdata_o,
    output logic        ee_sk_o,
    output logic        ee_cs_o,
    output logic        ee_di_o,
    input  logic        ee_do_i
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              wen;
        logic              err;
    } host_t;

    host_t q, d;

    cmd_kind_e          kind;
    logic               start, err_set, set_wen, busy;
    logic               rd_done;
    logic [DATA_W-1:0]  rd_word;
    logic [FRAME_W-1:0] frame;
    logic [BCNT_W-1:0]  last_idx;
    logic               long_frame;

    eeprom_cmd_decode u_dec (
        .cmd_wr   (cmd_wr_i),
        .cmd_word (cmd_wdata_i),
        .wen      (q.wen),
        .busy     (busy),
        .kind     (kind),
        .start    (start),
        .err_set  (err_set),
        .set_wen  (set_wen)
    );

    always_comb begin
        long_frame = (kind == K_READ) || (kind == K_WRITE);
        last_idx   = long_frame ? BCNT_W'(FRAME_W - 1) : BCNT_W'(HDR_W - 1);
        frame      = {1'b1, cmd_wdata_i[7:6], cmd_wdata_i[ADDR_W-1:0],
                      (kind == K_WRITE) ? q.data : {DATA_W{1'b0}}};
    end

    eeprom_serial_shifter #(.CLK_DIV(CLK_DIV)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frame    (frame),
        .last_idx (last_idx),
        .capture  (kind == K_READ),
        .sdo      (ee_do_i),
        .busy     (busy),
        .sk       (ee_sk_o),
        .cs       (ee_cs_o),
        .sdi      (ee_di_o),
        .rd_done  (rd_done),
        .rd_word  (rd_word)
    );

    always_comb begin
        d = q;
        if (data_wr_i) d.data = data_wdata_i;
        if (rd_done)   d.data = rd_word;
        if (set_wen)   d.wen  = 1'b1;
        if (err_set)   d.err  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_rdata_o  = {busy, q.wen, q.err, 13'b0};
    assign data_rdata_o = q.data;
endmodule

// File: rtl/eeprom_cmd_ctrl_chk.sv
module eeprom_cmd_ctrl_chk #(
    parameter int CLK_DIV = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [7:0]  cmd_low,
    input logic        data_wr,
    input logic [15:0] cmd_rd,
    input logic [15:0] data_rd,
    input logic        sk,
    input logic        cs
);
    logic busy, wen, err;
    assign busy = cmd_rd[15];
    assign wen  = cmd_rd[14];
    assign err  = cmd_rd[13];

    p_idle_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sk && !cs));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_drop_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> err);

    p_wen_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wen |=> wen);

    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !data_wr) |=> $stable(data_rd));

    p_locked_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && !wen && (cmd_low[6] == 1'b1)) |=> !busy);

    generate
        if (CLK_DIV > 1) begin : g_slow
            p_sk_high_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(sk) |=> sk);
        end
    endgenerate
endmodule

bind eeprom_cmd_ctrl eeprom_cmd_ctrl_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (cmd_wr_i),
    .cmd_low (cmd_wdata_i[7:0]),
    .data_wr (data_wr_i),
    .cmd_rd  (cmd_rdata_o),
    .data_rd (data_rdata_o),
    .sk      (ee_sk_o),
    .cs      (ee_cs_o)
);

// File: tb/eeprom_cmd_ctrl_tb.sv
module ee_resp_model (
    input  logic sk,
    input  logic cs,
    input  logic di,
    output logic dout
);
    logic [15:0] mem [64];
    logic [63:0] touched = '0;
    int          cnt = 0;
    logic [8:0]  hdr = '0;
    logic [15:0] wsh = '0;
    int          frame_errs = 0;

    function automatic logic [15:0] init_word(input int a);
        case (a)
            3:       return 16'h9150;
            7:       return 16'h6D50;
            8:       return 16'h0310;
            9:       return 16'hA000;
            default: return 16'h1000 + 16'(a) * 16'h0101;
        endcase
    endfunction

    function automatic logic [15:0] word(input int a);
        return touched[a] ? mem[a] : init_word(a);
    endfunction

    logic [15:0] cur;
    always_comb begin
        cur  = word(int'(hdr[5:0]));
        dout = (cs && cnt >= 9 && cnt <= 24 && hdr[7:6] == 2'b10) ? cur[24-cnt] : 1'b0;
    end

    always @(posedge sk or negedge cs) begin
        if (!cs) begin
            if (hdr[8] != 1'b1) frame_errs++;
            case (hdr[7:6])
                2'b01: begin
                    if (cnt != 25) frame_errs++;
                    mem[hdr[5:0]] = wsh; touched[hdr[5:0]] = 1'b1;
                end
                2'b11: begin
                    if (cnt != 9) frame_errs++;
                    mem[hdr[5:0]] = 16'hFFFF; touched[hdr[5:0]] = 1'b1;
                end
                2'b10: if (cnt != 25) frame_errs++;
                default: if (cnt != 9 || hdr[5:4] != 2'b11) frame_errs++;
            endcase
            cnt = 0;
            hdr = '0;
        end else begin
            if (cnt < 9) hdr = {hdr[7:0], di};
            else         wsh = {wsh[14:0], di};
            cnt++;
        end
    end
endmodule

module eeprom_cmd_ctrl_tb;
    localparam int CLK_DIV = 2;
    localparam int LONG_CYC  = 25 * 2 * CLK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0, data_wr = 1'b0;
    logic [15:0] cmd_wdata = '0, data_wdata = '0;
    logic [15:0] cmd_rdata, data_rdata;
    logic        sk, cs, di, dout;

    int errors = 0, checks = 0;
    int rises = 0;
    int busy_cyc;
    bit finished = 0;

    always #5 clk = ~clk;

    eeprom_cmd_ctrl #(.CLK_DIV(CLK_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
        .data_wr_i(data_wr), .data_wdata_i(data_wdata),
        .cmd_rdata_o(cmd_rdata), .data_rdata_o(data_rdata),
        .ee_sk_o(sk), .ee_cs_o(cs), .ee_di_o(di), .ee_do_i(dout)
    );

    ee_resp_model u_mem (.sk(sk), .cs(cs), .di(di), .dout(dout));

    always @(posedge sk) rises++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [15:0] cmd;
        logic [15:0] wdat;
        logic        accept;
        logic        longf;
        logic        chk;
        logic [15:0] exp;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'h0087, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h6D50, "R1 "},
        '{16'h0083, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h9150, "R1 "},
        '{16'h0089, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hA000, "R1 "},
        '{16'h0045, 16'h1234, 1'b0, 1'b0, 1'b0, 16'h0000, "R5 "},
        '{16'h0085, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h1505, "R5 "},
        '{16'h00C6, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, "R5 "},
        '{16'h0086, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h1606, "R5 "},
        '{16'h0030, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, "R4 "},
        '{16'h0045, 16'h1234, 1'b1, 1'b1, 1'b0, 16'h0000, "R2 "},
        '{16'h0085, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h1234, "R2 "},
        '{16'h00C6, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, "R3 "},
        '{16'h0086, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hFFFF, "R3 "},
        '{16'h00BF, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h4F3F, "R1 "}
    };

    // Writes the data register, issues the command, then counts busy cycles.
    task automatic run_cmd(input logic [15:0] c, input logic [15:0] w);
        @(negedge clk); data_wr = 1'b1; data_wdata = w;
        @(negedge clk); data_wr = 1'b0; cmd_wr = 1'b1; cmd_wdata = c; rises = 0;
        @(negedge clk); cmd_wr = 1'b0;
        busy_cyc = 0;
        for (int t = 0; t < 2000 && cmd_rdata[15]; t++) begin
            busy_cyc++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        for (int t = 0; t < 150000; t++) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 cmd", cmd_rdata, 16'h0000);
        check("R10 data", data_rdata, 16'h0000);
        check("R10 pins", {sk, cs}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = string'(VECS[i].tag);
            run_cmd(VECS[i].cmd, VECS[i].wdat);
            // R6 busy length, R8 rising-edge count per frame
            check({tg, " R6 busy cycles"}, busy_cyc,
                  !VECS[i].accept ? 0 : (VECS[i].longf ? LONG_CYC : 9 * 2 * CLK_DIV));
            check({tg, " R8 sk rises"}, rises,
                  !VECS[i].accept ? 0 : (VECS[i].longf ? 25 : 9));
            check({tg, " R8 idle pins"}, {sk, cs}, 2'b00);
            if (VECS[i].chk) check({tg, " data"}, data_rdata, VECS[i].exp);
        end
        // R4: write enable visible on bit 14
        check("R4 wen bit", cmd_rdata[14], 1'b1);
        check("R8 frame format", u_mem.frame_errs, 0);

        // R9: host data write on the exact read completion edge loses
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = 16'h0083;
        @(negedge clk); cmd_wr = 1'b0;
        repeat (LONG_CYC - 1) @(negedge clk);
        check("R6 busy before last edge", cmd_rdata[15], 1'b1);
        data_wr = 1'b1; data_wdata = 16'hBEEF;
        @(negedge clk); data_wr = 1'b0;
        check("R6 busy after last edge", cmd_rdata[15], 1'b0);
        check("R9 read wins collision", data_rdata, 16'h9150);
        // R9: non-read frame keeps the word
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = 16'h0030;
        @(negedge clk); cmd_wr = 1'b0;
        repeat (60) @(negedge clk);
        check("R9 word retained", data_rdata, 16'h9150);

        // R7: command during a running read is dropped
        check("R7 err clear", cmd_rdata[13], 1'b0);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = 16'h0087; rises = 0;
        @(negedge clk); cmd_wr = 1'b0;
        repeat (20) @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = 16'h0082;
        @(negedge clk); cmd_wr = 1'b0;
        check("R7 err set", cmd_rdata[13], 1'b1);
        repeat (LONG_CYC) @(negedge clk);
        check("R7 first read intact", data_rdata, 16'h6D50);
        check("R7 single frame", rises, 25);
        run_cmd(16'h0082, 16'h0000);
        check("R7 err sticky", cmd_rdata[13], 1'b1);
        check("R1 read after drop", data_rdata, 16'h1202);

        // R5: nonzero upper byte ignored
        run_cmd(16'h0183, 16'h0000);
        check("R5 upper byte busy", busy_cyc, 0);

        // R10/R5: reset clears latch and error; write is then ignored
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R10 cmd after reset", cmd_rdata, 16'h0000);
        run_cmd(16'h0045, 16'h5555);
        check("R5 locked after reset", busy_cyc, 0);
        run_cmd(16'h0085, 16'h0000);
        check("R5 word untouched", data_rdata, 16'h1234);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule